// File: doc/BRIEF.md
# DMA Page Register Bank with Autoinitialize

This block holds the page byte, bits 23:16 of a 32-bit DMA memory address, for each of seven DMA channels, numbered 0–3 and 5–7. A processor or bus master reaches the bank through an 8-bit I/O port address and a plain read/write strobe. Every channel has two registers. The visible "current" register drives the DMA address generator. A hidden "base" copy is loaded by the same processor write. The base copy is what the current register falls back to on an autoinitialize. The high page byte and the address counter that supply the other address bits live outside this block.

An autoinitialize happens when a channel has autoinitialize enabled and reaches terminal count or receives end-of-process. On that event the current register takes the base value. For chaining or scatter-gather operation, a separate per-channel load path writes the base register alone, for example with the page of a reserve buffer. Eight further ports are plain scratch bytes with no effect on any channel.

Internally the channel index `k` runs 0..6 and maps to DMA channels 0,1,2,3,5,6,7. The page bus `page_out` carries channel index `k` in bits `[8k+7:8k]`. The same mapping and slicing apply to `base_ld_data`.

Top module: `dma_page_bank`

## Requirements
- R1: Channel ports are decoded as follows: DMA channel 0 at 87h, 1 at 83h, 2 at 81h, 3 at 82h, 5 at 8Bh, 6 at 89h, 7 at 8Ah.
- R2: A write strobe to a channel port, with no master clear, sets both the current and the base register of that channel to `bus_wdata`. The new current value appears on `page_out` one clock later.
- R3: A read strobe to a channel port returns that channel's current register on `bus_rdata`, in the same cycle, with `bus_ack` high. No port ever returns the base register.
- R4: When `auto_en[k]` is high and `tc[k]` or `eop[k]` is high, the current register of channel k takes the base value that held before that edge. With `auto_en[k]` low, `tc[k]` and `eop[k]` have no effect.
- R5: A synchronous low on `rst_n`, or a one-cycle `mclr` pulse, clears the current and base registers of every channel to 00h.
- R6: A write in the same cycle as `mclr` is ignored, and the clear wins. This holds for scratch ports too.
- R7: If a processor write and an autoinitialize hit the same channel in one cycle, the processor write decides both registers.
- R8: `base_ld[k]` loads `base_ld_data` for channel k into the base register only, leaving current unchanged. A processor write to that channel in the same cycle takes priority.
- R9: Ports 80h, 84h, 85h, 86h, 88h, 8Ch, 8Dh and 8Eh are read/write scratch bytes with `bus_ack`. They are not reset, not cleared by `mclr`, and have no effect on `page_out`.
- R10: An access to any other port asserts no `bus_ack`, reads 00h, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclr | input | 1 | Master-clear pulse |
| bus_addr | input | 8 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, 00h when not reading a decoded port |
| bus_ack | output | 1 | Access hit a decoded port |
| auto_en | input | 7 | Per-channel autoinitialize enable |
| tc | input | 7 | Per-channel terminal count |
| eop | input | 7 | Per-channel end-of-process |
| base_ld | input | 7 | Per-channel base-only load |
| base_ld_data | input | 56 | Base-only load bytes, 8 per channel |
| page_out | output | 56 | Current page bytes, 8 per channel |

## Verification
The bench drives collisions on one channel in one cycle: write with reload, write with base-only load, write with master clear, and reload with base-only load. A design with the wrong priority would leave the reloaded or base-loaded byte where the written byte belongs, or would let a write survive the clear. A base-only load followed by terminal count checks that the reload uses the hidden copy. A design that reloads from the wrong copy, or that reloads with the enable low, shows a page byte that differs from the reference. Reads of every port, including undecoded ones, catch a swapped channel address, a scratch byte that leaks into a channel, and an acknowledge on a port that does not exist.

// File: rtl/dma_page_pkg.sv
// Package: shared widths, counts and the fixed port map of the page bank.
// Assumes 8-bit I/O addresses; channel index k = 0..6 stands for DMA channels 0,1,2,3,5,6,7.
package dma_page_pkg;
    localparam int PAGE_W = 8;
    localparam int ADDR_W = 8;
    localparam int N_CHAN = 7;
    localparam int N_SCR  = 8;

    typedef logic [PAGE_W-1:0] page_t;

    // Port address of channel index k (order fixed by the DMA channel wiring)
    function automatic logic [ADDR_W-1:0] chan_port(input int k);
        case (k)
            0:       return 8'h87;
            1:       return 8'h83;
            2:       return 8'h81;
            3:       return 8'h82;
            4:       return 8'h8B;
            5:       return 8'h89;
            6:       return 8'h8A;
            default: return 8'h00;
        endcase
    endfunction

    // Port address of scratch byte j
    function automatic logic [ADDR_W-1:0] scratch_port(input int j);
        case (j)
            0:       return 8'h80;
            1:       return 8'h84;
            2:       return 8'h85;
            3:       return 8'h86;
            4:       return 8'h88;
            5:       return 8'h8C;
            6:       return 8'h8D;
            7:       return 8'h8E;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/dma_page_decode.sv
// Address decoder: turns an I/O port address into one-hot selects for the
// channel registers and the scratch bytes, plus a hit flag.
// Assumes the port map in dma_page_pkg has no duplicate addresses.
module dma_page_decode
    import dma_page_pkg::*;
#(
    parameter int NCH  = N_CHAN,
    parameter int NSCR = N_SCR,
    parameter int AW   = ADDR_W
) (
    input  logic [AW-1:0]   addr,
    output logic [NCH-1:0]  ch_sel,
    output logic [NSCR-1:0] scr_sel,
    output logic            hit
);
    // One comparator per channel port
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        assign ch_sel[k] = (addr == chan_port(k));
    end

    // One comparator per scratch port
    for (genvar j = 0; j < NSCR; j++) begin : g_scr
        assign scr_sel[j] = (addr == scratch_port(j));
    end

    assign hit = (|ch_sel) | (|scr_sel);

    // a_r1_single_select: a port maps to at most one register
    always_comb begin
        a_r1_single_select: assert ($onehot0({ch_sel, scr_sel}));
    end
endmodule

// File: rtl/dma_page_chan.sv
// One channel's page state: a visible current byte and a hidden base byte.
// Priority, highest first: reset or master clear, processor write, then
// autoinitialize reload (current) and base-only load (base). The reload uses
// the base value held before the edge.
module dma_page_chan #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mclr,
    input  logic          wr_sel,
    input  logic [PW-1:0] wdata,
    input  logic          auto_en,
    input  logic          tc,
    input  logic          eop,
    input  logic          base_ld,
    input  logic [PW-1:0] base_data,
    output logic [PW-1:0] cur
);
    logic [PW-1:0] base_q;
    logic          reload;

    assign reload = auto_en & (tc | eop);

    // Update the current and base bytes by priority
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            cur    <= '0;
            base_q <= '0;
        end else if (wr_sel) begin
            cur    <= wdata;
            base_q <= wdata;
        end else begin
            if (reload)  cur    <= base_q;
            if (base_ld) base_q <= base_data;
        end
    end

    a_r2_write_loads_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !mclr) |=> (cur == $past(wdata) && base_q == $past(wdata)));

    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (cur == '0 && base_q == '0));

    a_r4_reload_from_base: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !wr_sel && !mclr) |=> (cur == $past(base_q)));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !wr_sel && !mclr) |=> $stable(cur));

    a_r8_base_only: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ld && !wr_sel && !mclr) |=> (base_q == $past(base_data)));
endmodule

// File: rtl/dma_page_scratch.sv
// Scratch bytes: plain read/write storage with no reset and no DMA effect.
// Assumes the caller already removed writes that collide with master clear.
module dma_page_scratch #(
    parameter int PW   = 8,
    parameter int NSCR = 8
) (
    input  logic             clk,
    input  logic [NSCR-1:0]  wr_sel,
    input  logic [PW-1:0]    wdata,
    output logic [NSCR*PW-1:0] q
);
    for (genvar j = 0; j < NSCR; j++) begin : g_byte
        // Store the written byte
        always_ff @(posedge clk) begin
            if (wr_sel[j]) q[j*PW +: PW] <= wdata;
        end

        a_r9_scratch_write: assert property (@(posedge clk)
            wr_sel[j] |=> (q[j*PW +: PW] == $past(wdata)));
    end
endmodule

// File: rtl/dma_page_bank.sv
// Top of the page bank: decodes the register port, holds seven channel page
// registers with hidden base copies plus eight scratch bytes, and drives the
// current page bytes to the DMA address generator.
// Assumes single-cycle read/write strobes; read data and ack are combinational.
module dma_page_bank
    import dma_page_pkg::*;
#(
    parameter int NCH  = N_CHAN,
    parameter int NSCR = N_SCR,
    parameter int PW   = PAGE_W,
    parameter int AW   = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [PW-1:0]      bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [PW-1:0]      bus_rdata,
    output logic               bus_ack,
    input  logic [NCH-1:0]     auto_en,
    input  logic [NCH-1:0]     tc,
    input  logic [NCH-1:0]     eop,
    input  logic [NCH-1:0]     base_ld,
    input  logic [NCH*PW-1:0]  base_ld_data,
    output logic [NCH*PW-1:0]  page_out
);
    logic [NCH-1:0]     ch_sel;
    logic [NSCR-1:0]    scr_sel;
    logic               hit;
    logic               wr_ok;
    logic [NSCR*PW-1:0] scr_q;

    // A write that collides with master clear is dropped
    assign wr_ok = bus_wr & ~mclr;

    dma_page_decode #(.NCH(NCH), .NSCR(NSCR), .AW(AW)) i_dec (
        .addr    (bus_addr),
        .ch_sel  (ch_sel),
        .scr_sel (scr_sel),
        .hit     (hit)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        dma_page_chan #(.PW(PW)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .mclr      (mclr),
            .wr_sel    (wr_ok & ch_sel[k]),
            .wdata     (bus_wdata),
            .auto_en   (auto_en[k]),
            .tc        (tc[k]),
            .eop       (eop[k]),
            .base_ld   (base_ld[k]),
            .base_data (base_ld_data[k*PW +: PW]),
            .cur       (page_out[k*PW +: PW])
        );

        a_r3_read_current: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && ch_sel[k]) |-> (bus_rdata == page_out[k*PW +: PW] && bus_ack));
    end

    dma_page_scratch #(.PW(PW), .NSCR(NSCR)) i_scr (
        .clk    (clk),
        .wr_sel (scr_sel & {NSCR{wr_ok}}),
        .wdata  (bus_wdata),
        .q      (scr_q)
    );

    // Read mux: OR of the selected byte, zero when nothing is selected
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int k = 0; k < NCH; k++)
                if (ch_sel[k]) bus_rdata |= page_out[k*PW +: PW];
            for (int j = 0; j < NSCR; j++)
                if (scr_sel[j]) bus_rdata |= scr_q[j*PW +: PW];
        end
    end

    // Acknowledge any access to a decoded port
    assign bus_ack = (bus_rd | bus_wr) & hit;

    a_r10_no_ack_undecoded: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!bus_ack && bus_rdata == '0));

    a_r6_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (page_out == '0));
endmodule

// File: tb/test_dma_page_bank.sv
// Bench: behavioural reference of the page bank, compared every clock.
module test_dma_page_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_ack;
    logic [6:0]  auto_en = '0;
    logic [6:0]  tc = '0;
    logic [6:0]  eop = '0;
    logic [6:0]  base_ld = '0;
    logic [55:0] base_ld_data = '0;
    logic [55:0] page_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // reference state
    int m_cur[7];
    int m_base[7];
    int m_scr[8];
    int cport[7] = '{'h87, 'h83, 'h81, 'h82, 'h8B, 'h89, 'h8A};
    int sport[8] = '{'h80, 'h84, 'h85, 'h86, 'h88, 'h8C, 'h8D, 'h8E};

    dma_page_bank i_dma_page_bank (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .auto_en(auto_en),
        .tc(tc), .eop(eop), .base_ld(base_ld), .base_ld_data(base_ld_data),
        .page_out(page_out)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model step at a clock edge, from inputs held since the last falling edge
    task automatic model_edge();
        int nc[7];
        int nb[7];
        for (int k = 0; k < 7; k++) begin
            nc[k] = m_cur[k];
            nb[k] = m_base[k];
        end
        if (!rst_n || mclr) begin
            for (int k = 0; k < 7; k++) begin nc[k] = 0; nb[k] = 0; end
        end else begin
            for (int k = 0; k < 7; k++) begin
                if (bus_wr && bus_addr == cport[k]) begin
                    nc[k] = bus_wdata; nb[k] = bus_wdata;
                end else begin
                    if (auto_en[k] && (tc[k] || eop[k])) nc[k] = m_base[k];
                    if (base_ld[k]) nb[k] = base_ld_data[k*8 +: 8];
                end
            end
        end
        if (bus_wr && !mclr)
            for (int j = 0; j < 8; j++)
                if (bus_addr == sport[j]) m_scr[j] = bus_wdata;
        for (int k = 0; k < 7; k++) begin
            m_cur[k] = nc[k];
            m_base[k] = nb[k];
        end
    endtask

    // one clock: update reference, then compare every page byte
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int k = 0; k < 7; k++)
            check(tag, int'(page_out[k*8 +: 8]), m_cur[k]);
        bus_wr = 0; bus_rd = 0; mclr = 0;
        tc = '0; eop = '0; base_ld = '0;
    endtask

    task automatic wr(int a, int d, string tag);
        bus_addr = a[7:0]; bus_wdata = d[7:0]; bus_wr = 1;
        step(tag);
    endtask

    // read: compare combinational data and ack before the edge
    task automatic rd(int a, string tag);
        int exp;
        int hit;
        exp = 0; hit = 0;
        for (int k = 0; k < 7; k++) if (a == cport[k]) begin exp = m_cur[k]; hit = 1; end
        for (int j = 0; j < 8; j++) if (a == sport[j]) begin exp = m_scr[j]; hit = 1; end
        bus_addr = a[7:0]; bus_rd = 1;
        #1;
        check(tag, int'(bus_rdata), exp);
        check({tag, " ack"}, int'(bus_ack), hit);
        step(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 7; k++) begin m_cur[k] = 0; m_base[k] = 0; end
        for (int j = 0; j < 8; j++) m_scr[j] = 0;
        @(negedge clk);
        step("R5 reset");
        step("R5 reset");
        rst_n = 1;
        step("R5 reset hold");
        // R1/R2/R3: distinct byte per channel, read back
        for (int k = 0; k < 7; k++) wr(cport[k], 'h11 * (k + 1), "R2 write");
        for (int k = 0; k < 7; k++) rd(cport[k], "R1 R3 read");
        // R9 scratch bytes
        for (int j = 0; j < 8; j++) wr(sport[j], 'hA0 + j, "R9 scratch write");
        for (int j = 0; j < 8; j++) rd(sport[j], "R9 scratch read");
        // R10 undecoded ports
        wr('h8F, 'hFF, "R10 undecoded write");
        rd('h8F, "R10 undecoded read");
        rd('h00, "R10 undecoded read");
        // R4 autoinit disabled: tc has no effect
        wr(cport[2], 'h5C, "R2 write");
        base_ld[2] = 1; base_ld_data[23:16] = 8'h33; step("R8 base only");
        rd(cport[2], "R3 R8 current kept");
        tc[2] = 1; step("R4 tc without enable");
        // R4 reload from hidden base after tc and after eop
        auto_en = '1;
        tc[2] = 1; step("R4 reload tc");
        wr(cport[5], 'h77, "R2 write");
        base_ld[5] = 1; base_ld_data[47:40] = 8'h12; step("R8 base only");
        eop[5] = 1; step("R4 reload eop");
        // reload and base-only load together: reload takes old base
        base_ld[5] = 1; base_ld_data[47:40] = 8'h9E; tc[5] = 1; step("R4 R8 old base");
        tc[5] = 1; step("R4 new base");
        // R7 write beats reload, R8 write beats base load
        bus_addr = cport[0]; bus_wdata = 8'hC4; bus_wr = 1; tc[0] = 1;
        base_ld[0] = 1; base_ld_data[7:0] = 8'h01; step("R7 R8 write priority");
        tc[0] = 1; step("R7 base from write");
        // R6 clear with write in the same cycle
        bus_addr = cport[6]; bus_wdata = 8'hEE; bus_wr = 1; mclr = 1; step("R6 R5 clear wins");
        bus_addr = sport[3]; bus_wdata = 8'h44; bus_wr = 1; mclr = 1; step("R6 scratch write dropped");
        rd(sport[3], "R6 R9 scratch kept");
        for (int k = 0; k < 7; k++) begin tc[k] = 1; end
        step("R5 base cleared");
        // mixed stimulus against the reference
        for (int i = 0; i < 400; i++) begin
            int pick;
            pick = $urandom_range(0, 15);
            auto_en = 7'($urandom);
            tc = 7'($urandom); eop = 7'($urandom);
            base_ld = 7'($urandom); base_ld_data = {$urandom, $urandom};
            mclr = ($urandom_range(0, 31) == 0);
            bus_wdata = 8'($urandom);
            if (pick < 7) bus_addr = cport[pick][7:0];
            else if (pick < 15) bus_addr = sport[pick-7][7:0];
            else bus_addr = 8'($urandom);
            bus_wr = $urandom_range(0, 1);
            if (!bus_wr) begin
                int exp;
                int hit;
                exp = 0; hit = 0;
                for (int k = 0; k < 7; k++) if (bus_addr == cport[k]) begin exp = m_cur[k]; hit = 1; end
                for (int j = 0; j < 8; j++) if (bus_addr == sport[j]) begin exp = m_scr[j]; hit = 1; end
                bus_rd = 1;
                #1;
                check("R3 R9 R10 mixed read", int'(bus_rdata), exp);
                check("R10 mixed ack", int'(bus_ack), hit);
            end
            step("R2 R4 R7 R8 mixed");
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule